// File: doc/BRIEF.md
# Float to Signed Integer Truncator

This block converts a floating-point operand that has already been unpacked into a 32-bit two's-complement integer. It always rounds toward zero. The operand arrives as separate fields: a class code, a sign bit, a signed unbiased exponent and a normalized mantissa. The mantissa carries its leading one explicitly at its top bit, so the operand's value is mantissa × 2^(exponent − (MANT_W−1)).

The block keeps only the integer part of the magnitude. It applies the sign by two's-complement negation and reports an inexact flag whenever a nonzero fraction was dropped. Results that cannot be represented saturate according to the sign and raise an invalid-conversion flag. This applies to overflow, infinity and NaN. The range is asymmetric: −2^31 converts cleanly, but +2^31 saturates. The result, its flags and a valid strobe are registered and appear one clock after the input strobe.

Top module: `ftoi_trunc`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. While `in_valid` is low, `out_result`, `out_inexact` and `out_invalid` keep their values.
- R2: After synchronous reset, `out_valid`, `out_result`, `out_inexact` and `out_invalid` are all zero.
- R3: Class code 2'b00 (zero) yields a result of 0 with both flags low, whatever the sign, exponent and mantissa.
- R4: For class 2'b01 (number) with an in-range value, the result is floor(|x|) when the sign is 0 and −floor(|x|) in two's complement when the sign is 1. The result is never incremented.
- R5: For an in-range number, `out_inexact` is high if and only if at least one nonzero mantissa bit lies below the binary point.
- R6: A number with a negative exponent yields a result of 0 with `out_inexact` high and `out_invalid` low.
- R7: A number with an exponent of 32 or more raises `out_invalid` and saturates: 32'h7FFFFFFF for sign 0, 32'h80000000 for sign 1.
- R8: A number whose magnitude is at least 2^31 + sign also saturates with `out_invalid`. So −2^31 gives 32'h80000000 with no flags, and +2^31 gives 32'h7FFFFFFF with `out_invalid` high.
- R9: Class 2'b10 (infinity) and class 2'b11 (NaN) raise `out_invalid` and return 32'h7FFFFFFF + sign.
- R10: Whenever `out_invalid` is high, `out_inexact` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_cls | input | 2 | Class: 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W (10) | Signed unbiased exponent |
| in_mant | input | MANT_W (32) | Mantissa, leading one at the top bit |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | INT_W (32) | Two's-complement integer result |
| out_inexact | output | 1 | A nonzero fraction was discarded |
| out_invalid | output | 1 | Overflow, infinity or NaN saturated the result |

## Verification
The checker assumes that a class-01 operand always has its mantissa top bit set, as a normalized number should. The block's behaviour for an unnormalized mantissa is not specified.

The bench keeps within this assumption by forcing the top bit on every number mantissa it drives. It sweeps the exponent across both boundaries and out to both extremes of its signed range, for both signs and for a set of mantissa bit patterns. For the zero, infinity and NaN classes, the other fields are left free, since those classes must ignore them.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_NUM  = 2'b01,
    CLS_INF  = 2'b10,
    CLS_NAN  = 2'b11
  } fcls_e;

endpackage

// File: rtl/ftoi_shift.sv
// Right barrel shifter built from log2 stages. Each stage also collects
// whether it pushed any set bit out of the bottom.
module ftoi_shift #(
  parameter int MANT_W = 32,
  localparam int SH_W  = $clog2(MANT_W)
) (
  input  logic [MANT_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [MANT_W-1:0] dout,
  output logic              lost
);

  logic [SH_W:0][MANT_W-1:0] stg;
  logic [SH_W:0]             stk;

  assign stg[0] = din;
  assign stk[0] = 1'b0;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    localparam logic [MANT_W-1:0] LOW_MASK = {MANT_W{1'b1}} >> (MANT_W - STEP);
    assign stg[i+1] = amt[i] ? (stg[i] >> STEP) : stg[i];
    assign stk[i+1] = stk[i] | (amt[i] & (|(stg[i] & LOW_MASK)));
  end

  assign dout = stg[SH_W];
  assign lost = stk[SH_W];

endmodule

// File: rtl/ftoi_sat.sv
// Range check, sign application and saturation of an unsigned magnitude.
module ftoi_sat #(
  parameter int INT_W = 32
) (
  input  logic             sign,
  input  logic [INT_W-1:0] mag,
  input  logic             force_inv,
  output logic [INT_W-1:0] result,
  output logic             invalid
);

  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic ovf;

  // Magnitude >= 2^(INT_W-1) + sign is not representable.
  assign ovf     = mag[INT_W-1] & (~sign | (|mag[INT_W-2:0]));
  assign invalid = force_inv | ovf;

  always_comb begin
    if (invalid)   result = sign ? NEG_MIN : POS_MAX;
    else if (sign) result = (~mag) + INT_W'(1);
    else           result = mag;
  end

endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_cls,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_result,
  output logic              out_inexact,
  output logic              out_invalid
);
  import ftoi_pkg::*;

  localparam int SH_W = $clog2(MANT_W);
  localparam logic signed [EXP_W:0] EXP_LIM = (EXP_W+1)'(INT_W);

  fcls_e              cls;
  logic signed [EXP_W:0] exp_x;
  logic               exp_neg, exp_big, is_num, is_special;
  logic [SH_W-1:0]    sh_amt;
  logic [MANT_W-1:0]  shifted;
  logic               sh_lost;
  logic [INT_W-1:0]   mag;
  logic               lost;
  logic [INT_W-1:0]   sat_res;
  logic               sat_inv;
  logic [INT_W-1:0]   nx_res;
  logic               nx_inx, nx_inv;

  assign cls        = fcls_e'(in_cls);
  assign is_num     = (cls == CLS_NUM);
  assign is_special = (cls == CLS_INF) || (cls == CLS_NAN);
  assign exp_x      = {in_exp[EXP_W-1], in_exp};
  assign exp_neg    = in_exp[EXP_W-1];
  assign exp_big    = !exp_neg && (exp_x >= EXP_LIM);

  // Distance from the mantissa top bit to the binary point.
  assign sh_amt = SH_W'(MANT_W-1) - in_exp[SH_W-1:0];

  ftoi_shift #(.MANT_W(MANT_W)) u_shift (
    .din  (in_mant),
    .amt  (sh_amt),
    .dout (shifted),
    .lost (sh_lost)
  );

  always_comb begin
    if (exp_neg) begin
      mag  = '0;
      lost = |in_mant;
    end else begin
      mag  = shifted[INT_W-1:0];
      lost = sh_lost;
    end
  end

  ftoi_sat #(.INT_W(INT_W)) u_sat (
    .sign      (in_sign),
    .mag       (mag),
    .force_inv (is_special | (is_num & exp_big)),
    .result    (sat_res),
    .invalid   (sat_inv)
  );

  always_comb begin
    if (cls == CLS_ZERO) begin
      nx_res = '0;
      nx_inx = 1'b0;
      nx_inv = 1'b0;
    end else begin
      nx_res = sat_res;
      nx_inv = sat_inv;
      nx_inx = is_num & lost & ~sat_inv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nx_res;
        out_inexact <= nx_inx;
        out_invalid <= nx_inv;
      end
    end
  end

endmodule

// File: rtl/ftoi_trunc_chk.sv
module ftoi_trunc_chk #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        in_cls,
  input logic              in_sign,
  input logic [EXP_W-1:0]  in_exp,
  input logic [MANT_W-1:0] in_mant,
  input logic              out_valid,
  input logic [INT_W-1:0]  out_result,
  input logic              out_inexact,
  input logic              out_invalid
);

  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [EXP_W:0] EXP_LIM = (EXP_W+1)'(INT_W);

  logic signed [EXP_W:0] exp_x;
  assign exp_x = {in_exp[EXP_W-1], in_exp};

  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_result) && $stable(out_inexact)
                 && $stable(out_invalid));

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cls == 2'b00 |=> out_result == '0 && !out_inexact && !out_invalid);

  assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cls == 2'b01 && !in_sign |=> out_invalid || !out_result[INT_W-1]);

  assert_negexp_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cls == 2'b01 && in_exp[EXP_W-1]
    |=> out_result == '0 && out_inexact && !out_invalid);

  assert_bigexp_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cls == 2'b01 && !in_exp[EXP_W-1] && exp_x >= EXP_LIM
    |=> out_invalid && out_result == ($past(in_sign) ? NEG_MIN : POS_MAX));

  assert_special_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cls[1]
    |=> out_invalid && out_result == ($past(in_sign) ? NEG_MIN : POS_MAX));

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> !out_inexact);

endmodule

bind ftoi_trunc ftoi_trunc_chk #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_cls     (in_cls),
  .in_sign    (in_sign),
  .in_exp     (in_exp),
  .in_mant    (in_mant),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_inexact(out_inexact),
  .out_invalid(out_invalid)
);

// File: tb/sim_ftoi_trunc.sv
`timescale 1ns/1ps
module sim_ftoi_trunc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_cls = 2'b00;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_mant = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact;
  logic        out_invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ftoi_trunc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  task automatic chk(input string tag, input longint got, input longint want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, want);
    end
  endtask

  // Expected result from the requirements.
  task automatic model(input logic [1:0] cls, input logic sg, input int e,
                       input logic [31:0] m, output logic [31:0] r,
                       output logic inx, output logic inv);
    longint mag;
    longint lost;
    r = 0; inx = 0; inv = 0;
    if (cls == 2'b00) return;
    if (cls[1]) begin
      inv = 1; r = sg ? 32'h8000_0000 : 32'h7FFF_FFFF; return;
    end
    if (e >= 32) begin
      inv = 1; r = sg ? 32'h8000_0000 : 32'h7FFF_FFFF; return;
    end
    if (e < 0) begin
      mag = 0; lost = longint'(m);
    end else begin
      mag  = longint'(m) >> (31 - e);
      lost = longint'(m) & ((64'd1 << (31 - e)) - 1);
    end
    if (mag >= 64'h8000_0000 + longint'(sg)) begin
      inv = 1; r = sg ? 32'h8000_0000 : 32'h7FFF_FFFF; return;
    end
    r   = sg ? 32'(-mag) : 32'(mag);
    inx = (lost != 0);
  endtask

  task automatic apply(input string tag, input logic [1:0] cls, input logic sg,
                       input int e, input logic [31:0] m);
    logic [31:0] r;
    logic inx, inv;
    model(cls, sg, e, m, r, inx, inv);
    @(negedge clk);
    in_valid = 1; in_cls = cls; in_sign = sg; in_exp = 10'(e); in_mant = m;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R1 valid"}, out_valid, 1);
    chk({tag, " result"}, out_result, r);
    chk({tag, " inexact R5"}, out_inexact, inx);
    chk({tag, " invalid"}, out_invalid, inv);
  endtask

  logic [31:0] pats [8] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                           32'hC000_0000, 32'hAAAA_AAAA, 32'h9ABC_DEF0,
                           32'hFFFF_0000, 32'h8000_8000};

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 valid", out_valid, 0);
    chk("R2 result", out_result, 0);
    chk("R2 inexact", out_inexact, 0);
    chk("R2 invalid", out_invalid, 0);
    rst = 0;

    // R3: zero class ignores other fields
    apply("R3 zero+", 2'b00, 0, 5, 32'hFFFF_FFFF);
    apply("R3 zero-", 2'b00, 1, 40, 32'h8000_0001);

    // R8: asymmetric boundary
    apply("R8 neg 2^31", 2'b01, 1, 31, 32'h8000_0000);
    apply("R8 pos 2^31", 2'b01, 0, 31, 32'h8000_0000);
    apply("R8 neg 2^31+1", 2'b01, 1, 31, 32'h8000_0001);
    apply("R8 pos max", 2'b01, 0, 30, 32'hFFFF_FFFF);

    // R6: negative exponent
    apply("R6 e=-1", 2'b01, 0, -1, 32'hFFFF_FFFF);
    apply("R6 e=-512", 2'b01, 1, -512, 32'h8000_0000);

    // R7: large exponent
    apply("R7 e=32", 2'b01, 0, 32, 32'h8000_0000);
    apply("R7 e=511", 2'b01, 1, 511, 32'hFFFF_FFFF);

    // R9: specials
    for (int c = 2; c < 4; c++)
      for (int s = 0; s < 2; s++) begin
        apply("R9 special", 2'(c), 1'(s), 3, 32'h1234_5678);
      end

    // R4/R5/R10 sweep over exponent, sign and mantissa pattern
    for (int e = -40; e <= 40; e++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 8; p++) begin
          apply("R4 R10 sweep", 2'b01, 1'(s), e, pats[p] | 32'h8000_0000);
        end

    // R1: outputs hold while strobe is low
    apply("R1 prime", 2'b01, 1, 4, 32'hC000_0000);
    @(negedge clk);
    in_cls = 2'b11; in_sign = 0; in_exp = 10'd60; in_mant = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R1 idle valid", out_valid, 0);
    chk("R1 hold result", out_result, 32'hFFFF_FFE8);
    chk("R1 hold inexact", out_inexact, 0);
    chk("R1 hold invalid", out_invalid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule